// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises a processor interrupt after a programmed number of video scanlines. A host CPU writes four control registers. It can set a reload value, copy that value into the counter, switch the interrupt off (which also acknowledges a pending request), and switch it on. A separate single-cycle `line_tick` input advances the counter once per scanline. The logic that produces `line_tick` from video bus activity sits outside this block.

The counter is one bit wider than the reload value and is signed. It counts down to zero and then steps once more to -1. That step raises the request if the interrupt is enabled. After that the counter stays at -1 until software reloads it. For a short window after an acknowledge, a write to the reload register also loads the counter directly. That window ends at the next scanline tick.

Only address bits A15, A14, A13 and A0 take part in decoding, so each register is mirrored across its page. Writes have no back-pressure: every strobed write is taken in the cycle it is presented. If a write and a tick arrive in the same cycle, the write is applied first and the tick then acts on the result.

Top module: `scan_irq_counter`

## Requirements
- R1: A write is decoded only when `wr_page` (A15..A13) is 3'b110 or 3'b111. Any other page value leaves the counter, enable and request unchanged.
- R2: A write to page 3'b110 with `wr_odd`=0 stores `wr_data` as the reload value. Outside direct-load mode it leaves the counter untouched and marks the reload value as pending.
- R3: Direct-load mode starts on a write to page 3'b111 with `wr_odd`=0. While it is active, a page 3'b110 / `wr_odd`=0 write also puts `wr_data` straight into the counter and clears the pending mark.
- R4: A write to page 3'b110 with `wr_odd`=1 copies the stored reload value into the counter.
- R5: A write to page 3'b111 with `wr_odd`=0 clears the enable and drops `irq` at the next clock edge.
- R6: A write to page 3'b111 with `wr_odd`=1 sets the enable. If the pending mark is set, the same write also loads the counter from the reload value.
- R7: Each `line_tick` ends direct-load mode. If the counter is zero or positive, the tick also lowers it by one.
- R8: `irq` rises only on a tick that takes the counter from 0 to -1, and only if the enable is set after that cycle's write.
- R9: While the counter is negative, ticks leave it unchanged until a write loads it.
- R10: Once raised, `irq` stays high until a page 3'b111 / `wr_odd`=0 write or a reset.
- R11: Reset clears the counter, the reload value, the enable, the pending mark, direct-load mode and `irq`.
- R12: If a write and a tick arrive in the same cycle, the write takes effect first and the tick acts on the resulting state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_page | input | 3 | Address bits A15..A13 of the write |
| wr_odd | input | 1 | Address bit A0 of the write |
| wr_data | input | DATA_W | Write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| irq | output | 1 | Interrupt request, level, sticky |

## Verification
The bound checker watches these rules on every cycle:
- a raised request stays up until it is acknowledged;
- an acknowledge drops the request;
- the request can rise only on a tick while enabled;
- a non-negative counter steps down by exactly one on an undisturbed tick;
- an expired counter holds still;
- writes to unmapped pages change nothing.

Three behaviours need sequences that only the bench's scenarios drive:
- the direct-load window that opens at an acknowledge and closes at the next tick;
- the pending-dependent reload on enable;
- the ordering when a write and a tick share a cycle.

Because the counter is not a port, the bench checks them through the exact tick on which the request appears.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;

  // Page codes (A15..A13) that carry the four registers.
  localparam logic [2:0] PAGE_LOAD = 3'b110;
  localparam logic [2:0] PAGE_CTRL = 3'b111;

  // One-hot decoded register command.
  typedef struct packed {
    logic set_latch;
    logic force_load;
    logic irq_off;
    logic irq_on;
  } wr_cmd_t;

  localparam wr_cmd_t CMD_NONE = '{default: 1'b0};

endpackage

// File: rtl/scan_irq_decode.sv
module scan_irq_decode
  import scan_irq_pkg::*;
(
  input  logic       wr_en,
  input  logic [2:0] wr_page,
  input  logic       wr_odd,
  output wr_cmd_t    cmd
);

  always_comb begin
    cmd = CMD_NONE;
    if (wr_en) begin
      unique case (wr_page)
        PAGE_LOAD: begin
          cmd.set_latch  = ~wr_odd;
          cmd.force_load =  wr_odd;
        end
        PAGE_CTRL: begin
          cmd.irq_off = ~wr_odd;
          cmd.irq_on  =  wr_odd;
        end
        default: cmd = CMD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/scan_irq_ctrl.sv
module scan_irq_ctrl
  import scan_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_cmd_t           cmd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_tick,
  output logic              load,
  output logic [DATA_W-1:0] load_val,
  output logic              en_next,
  output logic              irq_clr,
  output logic              en_q
);

  logic [DATA_W-1:0] latch_q, latch_d;
  logic              pend_q, pend_d;
  logic              dir_q, dir_d;

  always_comb begin
    latch_d  = latch_q;
    pend_d   = pend_q;
    dir_d    = dir_q;
    en_next  = en_q;
    load     = 1'b0;
    load_val = latch_q;
    irq_clr  = 1'b0;

    if (cmd.set_latch) begin
      latch_d = wr_data;
      if (dir_q) begin
        load     = 1'b1;
        load_val = wr_data;
        pend_d   = 1'b0;
      end else begin
        pend_d   = 1'b1;
      end
    end
    if (cmd.force_load) load = 1'b1;
    if (cmd.irq_off) begin
      en_next = 1'b0;
      dir_d   = 1'b1;
      irq_clr = 1'b1;
    end
    if (cmd.irq_on) begin
      en_next = 1'b1;
      if (pend_q) load = 1'b1;
    end
    // A tick after the write closes the direct-load window.
    if (line_tick) dir_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      pend_q  <= 1'b0;
      dir_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      latch_q <= latch_d;
      pend_q  <= pend_d;
      dir_q   <= dir_d;
      en_q    <= en_next;
    end
  end

endmodule

// File: rtl/scan_irq_count.sv
module scan_irq_count #(
  parameter int DATA_W = 8,
  localparam int CW    = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              line_tick,
  input  logic              en_next,
  input  logic              irq_clr,
  output logic [CW-1:0]     cnt_q,
  output logic              irq_q
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] base, cnt_d;
  logic          step, fire;

  always_comb begin
    base  = load ? {1'b0, load_val} : cnt_q;
    step  = line_tick && !base[CW-1];
    cnt_d = step ? base - ONE : base;
    fire  = step && (base == '0) && en_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= (irq_q && !irq_clr) || fire;
    end
  end

endmodule

// File: rtl/scan_irq_counter.sv
module scan_irq_counter
  import scan_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_page,
  input  logic              wr_odd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_tick,
  output logic              irq
);

  localparam int CW = DATA_W + 1;

  wr_cmd_t           cmd;
  logic              load, en_next, irq_clr, en_q;
  logic [DATA_W-1:0] load_val;
  logic [CW-1:0]     cnt_q;

  scan_irq_decode u_dec (
    .wr_en  (wr_en),
    .wr_page(wr_page),
    .wr_odd (wr_odd),
    .cmd    (cmd)
  );

  scan_irq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .wr_data  (wr_data),
    .line_tick(line_tick),
    .load     (load),
    .load_val (load_val),
    .en_next  (en_next),
    .irq_clr  (irq_clr),
    .en_q     (en_q)
  );

  scan_irq_count #(.DATA_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .line_tick(line_tick),
    .en_next  (en_next),
    .irq_clr  (irq_clr),
    .cnt_q    (cnt_q),
    .irq_q    (irq)
  );

endmodule

// File: rtl/scan_irq_chk.sv
module scan_irq_chk #(
  parameter int DATA_W = 8,
  localparam int CW    = DATA_W + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_page,
  input logic          wr_odd,
  input logic          line_tick,
  input logic          irq,
  input logic          en_q,
  input logic [CW-1:0] cnt_q
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic ack_wr, mapped_wr, stray_wr;
  always_comb begin
    ack_wr    = wr_en && (wr_page == 3'b111) && !wr_odd;
    mapped_wr = wr_en && (wr_page[2:1] == 2'b11);
    stray_wr  = wr_en && (wr_page[2:1] != 2'b11);
  end

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !ack_wr |=> irq);

  a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> !irq);

  a_r8_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(line_tick));

  a_r8_rise_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> en_q);

  a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick && !cnt_q[CW-1] && !wr_en |=> cnt_q == $past(cnt_q) - ONE);

  a_r9_expired_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q[CW-1] && !mapped_wr |=> $stable(cnt_q));

  a_r1_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr && !line_tick |=> $stable(cnt_q) && $stable(irq) && $stable(en_q));

endmodule

bind scan_irq_counter scan_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_page  (wr_page),
  .wr_odd   (wr_odd),
  .line_tick(line_tick),
  .irq      (irq),
  .en_q     (en_q),
  .cnt_q    (cnt_q)
);

// File: tb/sim_scan_irq_counter.sv
`timescale 1ns/1ps
module sim_scan_irq_counter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_page = '0;
  logic       wr_odd = 1'b0;
  logic [7:0] wr_data = '0;
  logic       line_tick = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // Reference state
  int       m_cnt;
  bit [7:0] m_latch;
  bit       m_pend, m_dir, m_en, m_irq;

  always #2.5 clk = ~clk;

  scan_irq_counter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_page(wr_page),
    .wr_odd(wr_odd), .wr_data(wr_data), .line_tick(line_tick), .irq(irq)
  );

  task automatic chk(string tag, bit exp);
    n_chk++;
    if (irq !== exp) begin
      n_err++;
      $display("FAIL %s irq=%0b expected=%0b at %0t", tag, irq, exp, $time);
    end
  endtask

  task automatic mdl_reset();
    m_cnt = 0; m_latch = '0; m_pend = 0; m_dir = 0; m_en = 0; m_irq = 0;
  endtask

  // Write first, then tick (R12).
  task automatic mdl(bit w, bit [2:0] p, bit o, bit [7:0] d, bit t);
    if (w) begin
      case ({p, o})
        4'b1100: begin
          m_latch = d;
          if (m_dir) begin m_cnt = int'(d); m_pend = 0; end
          else m_pend = 1;
        end
        4'b1101: m_cnt = int'(m_latch);
        4'b1110: begin m_en = 0; m_irq = 0; m_dir = 1; end
        4'b1111: begin m_en = 1; if (m_pend) m_cnt = int'(m_latch); end
        default: ;
      endcase
    end
    if (t) begin
      m_dir = 0;
      if (m_cnt >= 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt < 0 && m_en) m_irq = 1;
      end
    end
  endtask

  task automatic step(bit w, bit [2:0] p, bit o, bit [7:0] d, bit t, string tag);
    @(negedge clk);
    wr_en = w; wr_page = p; wr_odd = o; wr_data = d; line_tick = t;
    @(posedge clk);
    #1;
    mdl(w, p, o, d, t);
    chk(tag, m_irq);
    wr_en = 0; line_tick = 0;
  endtask

  task automatic wr(bit [2:0] p, bit o, bit [7:0] d, string tag);
    step(1'b1, p, o, d, 1'b0, tag);
  endtask

  task automatic tk(string tag);
    step(1'b0, 3'b000, 1'b0, 8'h00, 1'b1, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5CA1_1E55));
    mdl_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.1;
    chk("R11 reset", 1'b0);

    // R8: expiring while disabled raises nothing; R9 expired counter holds
    tk("R8 disabled expiry");  chk("R8", 1'b0);
    wr(3'b111, 1'b1, 8'h00, "R6");
    tk("R9 expired");           chk("R9", 1'b0);

    // R2/R6: latch 3, enable loads it, fires on 4th tick
    wr(3'b110, 1'b0, 8'd3, "R2");
    wr(3'b111, 1'b1, 8'd0, "R6");
    for (int i = 0; i < 3; i++) begin tk("R6 count"); chk("R6", 1'b0); end
    tk("R8 fire");              chk("R8", 1'b1);

    // R10 sticky
    tk("R10"); tk("R10");       chk("R10", 1'b1);
    wr(3'b110, 1'b0, 8'd9, "R10"); chk("R10", 1'b1);

    // R5 acknowledge, R3 direct load
    wr(3'b111, 1'b0, 8'd0, "R5"); chk("R5", 1'b0);
    wr(3'b110, 1'b0, 8'd1, "R3");
    wr(3'b111, 1'b1, 8'd0, "R3");
    tk("R3");                   chk("R3", 1'b0);
    tk("R3");                   chk("R3", 1'b1);

    // R7 tick closes direct window, R2 latch leaves counter alone, R4 reload
    wr(3'b111, 1'b0, 8'd0, "R5");
    tk("R7");
    wr(3'b111, 1'b1, 8'd0, "R6");
    wr(3'b110, 1'b0, 8'd2, "R7");
    for (int i = 0; i < 3; i++) begin tk("R7 no load"); chk("R7", 1'b0); end
    wr(3'b110, 1'b1, 8'd0, "R4");
    tk("R4"); tk("R4");         chk("R4", 1'b0);
    tk("R4");                   chk("R4", 1'b1);

    // R1: unmapped pages do nothing
    wr(3'b111, 1'b0, 8'd0, "R5");
    wr(3'b110, 1'b0, 8'd2, "R3");
    tk("R1"); tk("R1"); tk("R1");
    wr(3'b111, 1'b1, 8'd0, "R6");
    wr(3'b100, 1'b1, 8'd0, "R1");
    wr(3'b101, 1'b1, 8'd0, "R1");
    wr(3'b000, 1'b1, 8'd0, "R1");
    wr(3'b011, 1'b0, 8'd0, "R1");
    for (int i = 0; i < 3; i++) begin tk("R1"); chk("R1", 1'b0); end

    // R12: write and tick in the same cycle
    wr(3'b111, 1'b0, 8'd0, "R5");
    wr(3'b111, 1'b1, 8'd0, "R6");
    step(1'b1, 3'b110, 1'b0, 8'd0, 1'b1, "R12"); chk("R12", 1'b1);

    // Random traffic checked against the reference every cycle
    for (int i = 0; i < 4000; i++) begin
      bit       w = ($urandom_range(0, 9) >= 6);
      bit [2:0] p = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(0, 5))
                                                : 3'($urandom_range(6, 7));
      bit       o = 1'($urandom_range(0, 1));
      bit [7:0] d = ($urandom_range(0, 15) == 0) ? 8'($urandom_range(0, 255))
                                                 : 8'($urandom_range(0, 5));
      bit       t = ($urandom_range(0, 2) == 0);
      step(w, p, o, d, t, "R12 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule